// File: doc/BRIEF.md
# Frame Commit Buffer for Reassembled Preemptable Traffic

This block sits on the receive path for preemptable traffic, directly after the fragment reassembler. Each beat of a frame is written into a local buffer as it arrives. Nothing is shown downstream until the frame's final beat arrives with no error mark. At that moment the whole frame becomes visible in one step. It then leaves as a single unbroken burst, so the consumer never sees the gaps that can occur between fragments.

A frame whose final beat carries the error mark is rolled back without any notice. A frame that runs into a full buffer is also rolled back, together with all beats already stored for it. An overflow raises a one-cycle drop pulse and increments a saturating event counter. The rest of that frame is swallowed up to and including its last beat.

The input never applies back-pressure: `s_tready` is always high, and the block copes with a full buffer by dropping the frame. The output is valid/ready. While `m_tvalid` is high and `m_tready` is low, the presented beat is held unchanged. `DEPTH` must be a power of two, and a frame longer than `DEPTH` beats can never be delivered.

Top module: `frag_commit_fifo`

## Requirements
- R1: After reset, `m_tvalid` is 0, `drop_pulse` is 0 and `drop_count` is 0.
- R2: No beat of a frame is presented on the output before the final beat of that frame (`s_tlast`=1, `s_tuser`=0) is accepted. `m_tvalid` can rise at the earliest in the cycle after that beat.
- R3: Committed frames come out in arrival order with unchanged data, and `m_tlast` is 1 only on each frame's final beat.
- R4: Once a frame's first beat has been transferred, `m_tvalid` stays high on every cycle until that frame's `m_tlast` beat has been transferred.
- R5: A frame whose final beat has `s_tuser`=1 is discarded without a trace: no output beats, no `drop_pulse`, and `drop_count` unchanged.
- R6: A beat that arrives while the buffer holds `DEPTH` beats (committed plus unfinished) causes an overflow. `drop_pulse` is then 1 for exactly the following cycle, `drop_count` increases by one, and no beat of that frame is ever output.
- R7: After an overflow, the remaining beats of the dropped frame up to its `s_tlast` are ignored. The next frame is buffered normally.
- R8: `drop_count` saturates at 2^`CNT_W`-1. Overflows after that still pulse `drop_pulse` but leave the count unchanged.
- R9: `s_tready` is 1 in every cycle after reset.
- R10: While `m_tvalid`=1 and `m_tready`=0, `m_tvalid`, `m_tdata` and `m_tlast` stay unchanged into the next cycle.
- R11: Frames committed before a discarded frame, and frames accepted after it, are delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input ready, always 1 |
| s_tdata | input | DATA_W | Input beat data |
| s_tlast | input | 1 | Final beat of the frame |
| s_tuser | input | 1 | Error mark, sampled with `s_tlast` |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | DATA_W | Output beat data |
| m_tlast | output | 1 | Final beat of an output frame |
| drop_pulse | output | 1 | One-cycle pulse per overflow discard |
| drop_count | output | CNT_W | Saturating count of overflow discards |

## Verification
Good frames of one, three and five beats are sent with the output free-running and no earlier data waiting. This separates a correct commit from early leakage (the output must stay quiet until the last beat) and from reordering. An error-marked frame placed between good frames shows whether a rollback is silent and clean. With the output stalled, a good frame followed by an overlong frame and then a short good frame separates a correct rollback to the committed point from one that corrupts the frames on either side. A run of frames that each exceed the buffer drives the counter into saturation. Toggling `m_tready` while a frame is being read out exposes both hold violations and gaps inside the burst.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

  // Write-side mode: storing beats of the current frame, or swallowing
  // the tail of a frame that overflowed.
  typedef enum logic {
    WR_STORE = 1'b0,
    WR_FLUSH = 1'b1
  } wr_mode_e;

endpackage

// File: rtl/fcf_store.sv
module fcf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int EW    = DATA_W + 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [EW-1:0] wr_entry,
  input  logic [AW-1:0] rd_addr,
  output logic [EW-1:0] rd_entry
);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_entry;
  end

  assign rd_entry = mem[rd_addr];

endmodule

// File: rtl/fcf_wr_ctrl.sv
module fcf_wr_ctrl
  import fcf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          last,
  input  logic          err,
  input  logic [PW-1:0] rd_ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] commit_ptr,
  output logic          drop_pulse,
  output logic [CNT_W-1:0] drop_count
);

  localparam logic [PW-1:0] CAP = PW'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PW-1:0] spec_q, spec_d, commit_q, commit_d;
  wr_mode_e      mode_q, mode_d;
  logic          ovf;
  logic          full;
  logic [PW-1:0] spec_inc;

  assign spec_inc = spec_q + PW'(1);
  assign full     = (spec_q - rd_ptr) == CAP;

  always_comb begin
    spec_d   = spec_q;
    commit_d = commit_q;
    mode_d   = mode_q;
    wr_en    = 1'b0;
    ovf      = 1'b0;
    if (beat) begin
      unique case (mode_q)
        WR_FLUSH: begin
          if (last) mode_d = WR_STORE;
        end
        WR_STORE: begin
          if (full) begin
            ovf    = 1'b1;
            spec_d = commit_q;
            if (!last) mode_d = WR_FLUSH;
          end else begin
            wr_en = 1'b1;
            if (last && err) begin
              spec_d = commit_q;
            end else if (last) begin
              spec_d   = spec_inc;
              commit_d = spec_inc;
            end else begin
              spec_d = spec_inc;
            end
          end
        end
        default: mode_d = WR_STORE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spec_q     <= '0;
      commit_q   <= '0;
      mode_q     <= WR_STORE;
      drop_pulse <= 1'b0;
      drop_count <= '0;
    end else begin
      spec_q     <= spec_d;
      commit_q   <= commit_d;
      mode_q     <= mode_d;
      drop_pulse <= ovf;
      if (ovf && drop_count != CNT_MAX) drop_count <= drop_count + CNT_W'(1);
    end
  end

  assign wr_addr    = spec_q[AW-1:0];
  assign commit_ptr = commit_q;

endmodule

// File: rtl/fcf_rd_ctrl.sv
module fcf_rd_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] commit_ptr,
  input  logic          pop_ready,
  output logic          have_data,
  output logic [PW-1:0] rd_ptr
);

  logic [PW-1:0] rd_q;

  assign have_data = rd_q != commit_ptr;
  assign rd_ptr    = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_q <= '0;
    else if (have_data && pop_ready) rd_q <= rd_q + PW'(1);
  end

endmodule

// File: rtl/frag_commit_fifo.sv
module frag_commit_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tlast,
  input  logic              s_tuser,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast,
  output logic              drop_pulse,
  output logic [CNT_W-1:0]  drop_count
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int EW = DATA_W + 1;

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] commit_ptr;
  logic [PW-1:0] rd_ptr;
  logic [EW-1:0] rd_entry;

  assign s_tready = 1'b1;

  fcf_wr_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (s_tvalid),
    .last       (s_tlast),
    .err        (s_tuser),
    .rd_ptr     (rd_ptr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .commit_ptr (commit_ptr),
    .drop_pulse (drop_pulse),
    .drop_count (drop_count)
  );

  fcf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_entry ({s_tlast, s_tdata}),
    .rd_addr  (rd_ptr[AW-1:0]),
    .rd_entry (rd_entry)
  );

  fcf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_ptr (commit_ptr),
    .pop_ready  (m_tready),
    .have_data  (m_tvalid),
    .rd_ptr     (rd_ptr)
  );

  assign m_tdata = rd_entry[DATA_W-1:0];
  assign m_tlast = rd_entry[DATA_W];

endmodule

// File: rtl/fcf_chk.sv
module fcf_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_tvalid,
  input logic              s_tlast,
  input logic              s_tuser,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tlast,
  input logic              drop_pulse,
  input logic [CNT_W-1:0]  drop_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R10
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R4
  burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && !m_tlast) |=> m_tvalid);

  // R2
  release_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_tvalid) |-> $past(s_tvalid && s_tlast && !s_tuser));

  // R6
  count_moves_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_pulse && drop_count == $past(drop_count) + CNT_W'(1)));

  // R8
  count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == CNT_MAX) |=> (drop_count == CNT_MAX));

endmodule

bind frag_commit_fifo fcf_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_tvalid   (s_tvalid),
  .s_tlast    (s_tlast),
  .s_tuser    (s_tuser),
  .m_tvalid   (m_tvalid),
  .m_tready   (m_tready),
  .m_tdata    (m_tdata),
  .m_tlast    (m_tlast),
  .drop_pulse (drop_pulse),
  .drop_count (drop_count)
);

// File: tb/tb_frag_commit_fifo.sv
module tb_frag_commit_fifo;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tuser = 1'b0;
  logic [DATA_W-1:0] s_tdata = '0;
  logic s_tready, m_tvalid, m_tlast, drop_pulse;
  logic m_tready = 1'b0;
  logic [DATA_W-1:0] m_tdata;
  logic [CNT_W-1:0] drop_count;

  int checks = 0;
  int errors = 0;
  logic [DATA_W:0] exp_q [$];

  always #2.5 clk = ~clk;

  frag_commit_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard
  logic in_frame = 1'b0;
  logic prev_stall = 1'b0;
  logic [DATA_W:0] prev_beat;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(m_tvalid && {m_tlast, m_tdata} == prev_beat, "R10 hold", {m_tlast, m_tdata}, prev_beat);
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected beat", m_tdata, 0);
        end else begin
          logic [DATA_W:0] e;
          e = exp_q.pop_front();
          chk({m_tlast, m_tdata} == e, "R3 beat", {m_tlast, m_tdata}, e);
        end
        in_frame = !m_tlast;
      end else if (!m_tvalid && in_frame) begin
        chk(1'b0, "R4 gap in burst", 0, 1);
        in_frame = 1'b0;
      end
      prev_stall = m_tvalid && !m_tready;
      prev_beat  = {m_tlast, m_tdata};
    end
  end

  // Driver: ovf_at = beat index expected to overflow (-1: none).
  // hidden: check output quiet before the last beat (queue drained).
  task automatic send_frame(input int len, input bit err, input int base,
                            input int ovf_at, input bit hidden);
    bit commit;
    commit = !err && ovf_at < 0;
    for (int i = 0; i < len; i++) begin
      s_tvalid = 1'b1;
      s_tdata  = DATA_W'(base + i);
      s_tlast  = (i == len - 1);
      s_tuser  = err && (i == len - 1);
      if (i == len - 1 && commit)
        for (int k = 0; k < len; k++) exp_q.push_back({(k == len - 1), DATA_W'(base + k)});
      @(negedge clk);
      chk(drop_pulse == (i == ovf_at), "R6 drop pulse", drop_pulse, (i == ovf_at));
      if (hidden && i < len - 1) chk(!m_tvalid, "R2 hidden before commit", m_tvalid, 0);
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    s_tuser  = 1'b0;
  endtask

  task automatic drain();
    m_tready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!m_tvalid, "R11 drained", m_tvalid, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1, R9
    chk(!m_tvalid, "R1 m_tvalid", m_tvalid, 0);
    chk(!drop_pulse, "R1 drop_pulse", drop_pulse, 0);
    chk(drop_count == 0, "R1 drop_count", drop_count, 0);
    chk(s_tready, "R9 s_tready", s_tready, 1);

    // R2, R3: good frames, output free-running
    m_tready = 1'b1;
    send_frame(1, 1'b0, 32'h100, -1, 1'b1);
    drain();
    send_frame(3, 1'b0, 32'h200, -1, 1'b1);
    drain();
    send_frame(5, 1'b0, 32'h300, -1, 1'b1);
    send_frame(2, 1'b0, 32'h380, -1, 1'b0);
    drain();

    // R5: error-marked frame vanishes silently
    send_frame(4, 1'b1, 32'h400, -1, 1'b1);
    repeat (4) @(negedge clk);
    chk(drop_count == 0, "R5 count unchanged", drop_count, 0);
    send_frame(2, 1'b0, 32'h480, -1, 1'b0);
    drain();

    // R10, R4: stalled read-out with toggling ready
    m_tready = 1'b0;
    send_frame(6, 1'b0, 32'h500, -1, 1'b0);
    repeat (3) @(negedge clk);
    for (int c = 0; c < 20; c++) begin
      m_tready = c[0];
      @(negedge clk);
    end
    drain();
    chk(s_tready, "R9 s_tready", s_tready, 1);

    // R6, R7, R11: overflow between good frames
    m_tready = 1'b0;
    send_frame(6, 1'b0, 32'h600, -1, 1'b0);
    send_frame(12, 1'b0, 32'h700, DEPTH - 6, 1'b0);
    chk(drop_count == 1, "R6 count after overflow", drop_count, 1);
    send_frame(4, 1'b0, 32'h800, -1, 1'b0);
    drain();

    // R8: saturation with overlong frames
    m_tready = 1'b0;
    for (int k = 0; k < CMAX + 2; k++) begin
      send_frame(DEPTH + 1, 1'b0, 32'h900 + k * 32, DEPTH, 1'b0);
      chk(int'(drop_count) == ((k + 2 > CMAX) ? CMAX : k + 2), "R8 count",
          drop_count, (k + 2 > CMAX) ? CMAX : k + 2);
    end
    // R7: recovery
    m_tready = 1'b1;
    send_frame(3, 1'b0, 32'hA00, -1, 1'b1);
    drain();
    chk(drop_count == CMAX, "R8 count held", drop_count, CMAX);

    finish_run();
  end

endmodule